// File: doc/BRIEF.md
# Branch Target and Instruction-Set Interworking Unit

This unit works out where execution goes next after a branch-class operation, and which instruction set it runs in there. Each request names one of four branch kinds. There is a relative jump, a relative call that saves a return address, a register jump that may change the instruction set, and a register call that does both. Each request also carries the current fetch address, the current state bit, a signed byte offset, a register operand and an external condition-pass input. The unit does not evaluate conditions. The caller does that and reports the result on the pass input.

The core runs in one of two states. In the wide state instructions are four bytes long. In the compact state they are two bytes long. A relative branch adds its offset to the value the core sees when it reads the program counter as an operand. That value is eight bytes ahead of the current instruction in the wide state and four bytes ahead in the compact state. For a register branch, bit 0 of the operand picks the new state, and that bit is cleared in the fetch address. A register target that selects the wide state but is only halfword aligned is reported as misaligned. Such a branch is dropped.

A request is captured on a clock edge. Its result appears on the registered outputs after that edge and stays there for one cycle.

Top module: `branch_iw_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, every output is 0.
- R2: A request sampled with `req_vld_i`=1 on a clock edge drives `res_vld_o`=1 for exactly the following cycle. A cycle with no request yields `res_vld_o`=0 and all other outputs 0 in the following cycle.
- R3: When `cond_pass_i`=0 the branch is not taken. `res_taken_o`=0, the next address is the current address plus 4 (wide state, `cur_state_i`=0) or plus 2 (compact state, `cur_state_i`=1), the state is unchanged and `lr_we_o`=0.
- R4: A taken relative branch (kind 2'b00 jump or 2'b01 call) targets the operand PC value plus the offset. The operand PC value is the current address plus 8 in the wide state and plus 4 in the compact state. The low two bits of the target are cleared in the wide state and bit 0 is cleared in the compact state. The state is unchanged.
- R5: A taken call (kind 2'b01 or 2'b11) drives `lr_we_o`=1 with `lr_val_o` equal to the current address plus 4 in the wide state, or plus 2 with bit 0 set in the compact state. A jump (kind 2'b00 or 2'b10) never writes the link.
- R6: A taken register branch (kind 2'b10 or 2'b11) sets `res_state_o` to bit 0 of `reg_tgt_i` and `res_pc_o` to `reg_tgt_i` with bit 0 cleared.
- R7: A register branch that passes its condition but whose operand has bit 0 = 0 and bit 1 = 1 drives `misalign_o`=1 and is treated as not taken. It follows the fall-through address of R3, keeps the state and does not write the link.
- R8: A register call performs both the link write of R5, using the state it started in, and the target and state switch of R6.
- R9: `res_taken_o`=1 exactly when a request passes its condition and is not flagged misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Request present this cycle |
| req_kind_i | input | 2 | Branch kind: 00 jump, 01 call, 10 register jump, 11 register call |
| cond_pass_i | input | 1 | Condition result from the caller; 1 means take the branch |
| cur_pc_i | input | AW | Address of the branch instruction |
| cur_state_i | input | 1 | Current state: 0 wide, 1 compact |
| imm_off_i | input | AW | Signed byte offset for relative kinds |
| reg_tgt_i | input | AW | Register operand for register kinds |
| res_vld_o | output | 1 | Result present |
| res_taken_o | output | 1 | Branch took effect |
| res_pc_o | output | AW | Next fetch address |
| res_state_o | output | 1 | State at the next fetch address |
| lr_we_o | output | 1 | Link register write enable |
| lr_val_o | output | AW | Value for the link register |
| misalign_o | output | 1 | Register target selects the wide state but is halfword aligned |

## Verification
On every cycle the assertions check the one-cycle result timing. They also check that a failed condition falls through by the right step, that relative kinds never change state, that a register target's bit 0 becomes the new state and is cleared in the address, and that a misaligned target raises the flag, blocks the branch and suppresses the link write. The arithmetic is left to the bench scenarios: the operand PC offset in each state, the clearing of low target bits after an odd offset, and the link value with its state mark. The bench scenarios also cover back-to-back requests mixed with idle cycles, so that a result is shown to belong to its own request and not to a neighbour.

// File: rtl/btu_pkg.sv
package btu_pkg;

    typedef enum logic [1:0] {
        BK_JUMP      = 2'b00,
        BK_CALL      = 2'b01,
        BK_SWAP      = 2'b10,
        BK_CALLSWAP  = 2'b11
    } br_kind_e;

    function automatic logic kind_links(input br_kind_e k);
        return k[0];
    endfunction

    function automatic logic kind_from_reg(input br_kind_e k);
        return k[1];
    endfunction

endpackage

// File: rtl/btu_pc_view.sv
module btu_pc_view #(
    parameter int AW            = 32,
    parameter int WIDE_BYTES    = 4,
    parameter int COMPACT_BYTES = 2
) (
    input  logic [AW-1:0] pc_i,
    input  logic          state_i,
    output logic [AW-1:0] seq_pc_o,
    output logic [AW-1:0] rd_pc_o
);
    localparam logic [AW-1:0] WIDE_STEP     = AW'(WIDE_BYTES);
    localparam logic [AW-1:0] COMPACT_STEP  = AW'(COMPACT_BYTES);
    localparam logic [AW-1:0] WIDE_AHEAD    = AW'(2 * WIDE_BYTES);
    localparam logic [AW-1:0] COMPACT_AHEAD = AW'(2 * COMPACT_BYTES);

    always_comb begin
        seq_pc_o = pc_i + (state_i ? COMPACT_STEP : WIDE_STEP);
        rd_pc_o  = pc_i + (state_i ? COMPACT_AHEAD : WIDE_AHEAD);
    end
endmodule

// File: rtl/btu_target.sv
module btu_target #(
    parameter int AW            = 32,
    parameter int WIDE_BYTES    = 4,
    parameter int COMPACT_BYTES = 2
) (
    input  logic [AW-1:0] rd_pc_i,
    input  logic          state_i,
    input  logic          from_reg_i,
    input  logic [AW-1:0] imm_off_i,
    input  logic [AW-1:0] reg_tgt_i,
    output logic [AW-1:0] tgt_pc_o,
    output logic          tgt_state_o,
    output logic          misalign_o
);
    localparam logic [AW-1:0] WIDE_MASK    = ~AW'(WIDE_BYTES - 1);
    localparam logic [AW-1:0] COMPACT_MASK = ~AW'(COMPACT_BYTES - 1);
    localparam logic [AW-1:0] WIDE_LOW     = AW'(WIDE_BYTES - 1) & ~AW'(1);

    logic [AW-1:0] rel_sum;
    logic [AW-1:0] rel_pc;
    logic [AW-1:0] reg_pc;

    always_comb begin
        rel_sum = rd_pc_i + imm_off_i;
        rel_pc  = rel_sum & (state_i ? COMPACT_MASK : WIDE_MASK);
        reg_pc  = {reg_tgt_i[AW-1:1], 1'b0};
        if (from_reg_i) begin
            tgt_pc_o    = reg_pc;
            tgt_state_o = reg_tgt_i[0];
            misalign_o  = ~reg_tgt_i[0] & (|(reg_tgt_i & WIDE_LOW));
        end else begin
            tgt_pc_o    = rel_pc;
            tgt_state_o = state_i;
            misalign_o  = 1'b0;
        end
    end
endmodule

// File: rtl/btu_link.sv
module btu_link #(
    parameter int AW         = 32,
    parameter bit MARK_STATE = 1'b1
) (
    input  logic [AW-1:0] seq_pc_i,
    input  logic          state_i,
    output logic [AW-1:0] link_o
);
    generate
        if (MARK_STATE) begin : g_mark
            assign link_o = {seq_pc_i[AW-1:1], seq_pc_i[0] | state_i};
        end else begin : g_plain
            logic unused_state;
            assign unused_state = state_i;
            assign link_o = seq_pc_i;
        end
    endgenerate
endmodule

// File: rtl/branch_iw_unit.sv
module branch_iw_unit #(
    parameter int AW            = 32,
    parameter int WIDE_BYTES    = 4,
    parameter int COMPACT_BYTES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_vld_i,
    input  logic [1:0]    req_kind_i,
    input  logic          cond_pass_i,
    input  logic [AW-1:0] cur_pc_i,
    input  logic          cur_state_i,
    input  logic [AW-1:0] imm_off_i,
    input  logic [AW-1:0] reg_tgt_i,
    output logic          res_vld_o,
    output logic          res_taken_o,
    output logic [AW-1:0] res_pc_o,
    output logic          res_state_o,
    output logic          lr_we_o,
    output logic [AW-1:0] lr_val_o,
    output logic          misalign_o
);
    import btu_pkg::*;

    typedef struct packed {
        logic          vld;
        logic          taken;
        logic          misalign;
        logic          state;
        logic          lr_we;
        logic [AW-1:0] pc;
        logic [AW-1:0] lr;
    } result_t;

    result_t       res_d, res_q;
    br_kind_e      kind;
    logic [AW-1:0] seq_pc, rd_pc, tgt_pc, link_val;
    logic          tgt_state, tgt_misalign;

    assign kind = br_kind_e'(req_kind_i);

    btu_pc_view #(.AW(AW), .WIDE_BYTES(WIDE_BYTES), .COMPACT_BYTES(COMPACT_BYTES)) u_view (
        .pc_i     (cur_pc_i),
        .state_i  (cur_state_i),
        .seq_pc_o (seq_pc),
        .rd_pc_o  (rd_pc)
    );

    btu_target #(.AW(AW), .WIDE_BYTES(WIDE_BYTES), .COMPACT_BYTES(COMPACT_BYTES)) u_tgt (
        .rd_pc_i     (rd_pc),
        .state_i     (cur_state_i),
        .from_reg_i  (kind_from_reg(kind)),
        .imm_off_i   (imm_off_i),
        .reg_tgt_i   (reg_tgt_i),
        .tgt_pc_o    (tgt_pc),
        .tgt_state_o (tgt_state),
        .misalign_o  (tgt_misalign)
    );

    btu_link #(.AW(AW), .MARK_STATE(1'b1)) u_link (
        .seq_pc_i (seq_pc),
        .state_i  (cur_state_i),
        .link_o   (link_val)
    );

    always_comb begin
        logic bad_d, go_d;
        res_d = '0;
        bad_d = cond_pass_i & tgt_misalign;
        go_d  = cond_pass_i & ~tgt_misalign;
        if (req_vld_i) begin
            res_d.vld      = 1'b1;
            res_d.misalign = bad_d;
            res_d.taken    = go_d;
            res_d.pc       = go_d ? tgt_pc : seq_pc;
            res_d.state    = go_d ? tgt_state : cur_state_i;
            res_d.lr_we    = go_d & kind_links(kind);
            res_d.lr       = (go_d & kind_links(kind)) ? link_val : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_vld_o   = res_q.vld;
    assign res_taken_o = res_q.taken;
    assign res_pc_o    = res_q.pc;
    assign res_state_o = res_q.state;
    assign lr_we_o     = res_q.lr_we;
    assign lr_val_o    = res_q.lr;
    assign misalign_o  = res_q.misalign;
endmodule

// File: rtl/btu_checker.sv
module btu_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_vld_i,
    input logic [1:0]    req_kind_i,
    input logic          cond_pass_i,
    input logic [AW-1:0] cur_pc_i,
    input logic          cur_state_i,
    input logic [AW-1:0] reg_tgt_i,
    input logic          res_vld_o,
    input logic          res_taken_o,
    input logic [AW-1:0] res_pc_o,
    input logic          res_state_o,
    input logic          lr_we_o,
    input logic          misalign_o
);
    localparam logic [AW-1:0] STEP_W = AW'(4);
    localparam logic [AW-1:0] STEP_C = AW'(2);

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i |=> res_vld_o); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_i |=> !res_vld_o && !res_taken_o && !lr_we_o && !misalign_o); // R2
    AST_FAIL_FALLS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i && !cond_pass_i |=> !res_taken_o && !lr_we_o &&
        res_state_o == $past(cur_state_i) &&
        res_pc_o == $past(cur_pc_i) + ($past(cur_state_i) ? STEP_C : STEP_W)); // R3
    AST_REL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i && !req_kind_i[1] |=> res_state_o == $past(cur_state_i)); // R4
    AST_JUMP_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i && !req_kind_i[0] |=> !lr_we_o); // R5
    AST_SWAP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i && cond_pass_i && req_kind_i[1] && reg_tgt_i[1:0] != 2'b10 |=>
        res_taken_o && res_state_o == $past(reg_tgt_i[0]) && !res_pc_o[0]); // R6
    AST_MISALIGN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i && cond_pass_i && req_kind_i[1] && reg_tgt_i[1:0] == 2'b10 |=>
        misalign_o && !res_taken_o && !lr_we_o && res_state_o == $past(cur_state_i)); // R7
    AST_FLAG_EXCLUDES_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> !res_taken_o); // R9
endmodule

bind branch_iw_unit btu_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld_i   (req_vld_i),
    .req_kind_i  (req_kind_i),
    .cond_pass_i (cond_pass_i),
    .cur_pc_i    (cur_pc_i),
    .cur_state_i (cur_state_i),
    .reg_tgt_i   (reg_tgt_i),
    .res_vld_o   (res_vld_o),
    .res_taken_o (res_taken_o),
    .res_pc_o    (res_pc_o),
    .res_state_o (res_state_o),
    .lr_we_o     (lr_we_o),
    .misalign_o  (misalign_o)
);

// File: tb/sim_branch_iw_unit.sv
`timescale 1ns/1ps
module sim_branch_iw_unit;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_vld_i = 1'b0;
    logic [1:0]    req_kind_i = 2'b00;
    logic          cond_pass_i = 1'b0;
    logic [AW-1:0] cur_pc_i = '0;
    logic          cur_state_i = 1'b0;
    logic [AW-1:0] imm_off_i = '0;
    logic [AW-1:0] reg_tgt_i = '0;
    logic          res_vld_o, res_taken_o, res_state_o, lr_we_o, misalign_o;
    logic [AW-1:0] res_pc_o, lr_val_o;

    typedef struct packed {
        logic          vld;
        logic          taken;
        logic          mis;
        logic          st;
        logic          we;
        logic [AW-1:0] pc;
        logic [AW-1:0] lr;
    } exp_t;

    exp_t   exp_q[$];
    string  tag_q[$];
    int     cyc_q[$];
    int     cyc = 0;
    int     total = 0;
    int     bad = 0;
    bit     done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    branch_iw_unit #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld_i), .req_kind_i(req_kind_i),
        .cond_pass_i(cond_pass_i), .cur_pc_i(cur_pc_i), .cur_state_i(cur_state_i),
        .imm_off_i(imm_off_i), .reg_tgt_i(reg_tgt_i), .res_vld_o(res_vld_o),
        .res_taken_o(res_taken_o), .res_pc_o(res_pc_o), .res_state_o(res_state_o),
        .lr_we_o(lr_we_o), .lr_val_o(lr_val_o), .misalign_o(misalign_o)
    );

    function automatic exp_t model(input logic v, input logic [1:0] k, input logic p,
                                   input logic [AW-1:0] pc, input logic t,
                                   input logic [AW-1:0] off, input logic [AW-1:0] r);
        exp_t e = '0;
        logic [AW-1:0] fall, view;
        fall = pc + (t ? 32'd2 : 32'd4);
        view = pc + (t ? 32'd4 : 32'd8);
        if (!v) return e;
        e.vld   = 1'b1;
        e.mis   = p && k[1] && !r[0] && r[1];
        e.taken = p && !e.mis;
        if (!e.taken) begin
            e.pc = fall;
            e.st = t;
        end else if (k[1]) begin
            e.pc = {r[AW-1:1], 1'b0};
            e.st = r[0];
        end else begin
            e.pc = (view + off) & (t ? ~32'd1 : ~32'd3);
            e.st = t;
        end
        e.we = e.taken && k[0];
        e.lr = e.we ? (fall | {31'd0, t}) : '0;
        return e;
    endfunction

    task automatic issue(input string tag, input logic v, input logic [1:0] k, input logic p,
                         input logic [AW-1:0] pc, input logic t,
                         input logic [AW-1:0] off, input logic [AW-1:0] r);
        @(negedge clk);
        req_vld_i = v; req_kind_i = k; cond_pass_i = p; cur_pc_i = pc;
        cur_state_i = t; imm_off_i = off; reg_tgt_i = r;
        exp_q.push_back(model(v, k, p, pc, t, off, r));
        tag_q.push_back(tag);
        cyc_q.push_back(cyc);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0 && cyc_q[0] < cyc) begin
            exp_t e, a;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            void'(cyc_q.pop_front());
            a = {res_vld_o, res_taken_o, misalign_o, res_state_o, lr_we_o, res_pc_o, lr_val_o};
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s: actual vld=%b tk=%b mis=%b st=%b we=%b pc=%h lr=%h expected vld=%b tk=%b mis=%b st=%b we=%b pc=%h lr=%h",
                         tg, a.vld, a.taken, a.mis, a.st, a.we, a.pc, a.lr,
                         e.vld, e.taken, e.mis, e.st, e.we, e.pc, e.lr);
            end
        end
    end

    task automatic check_reset();
        logic [2*AW+4:0] o;
        o = {res_vld_o, res_taken_o, misalign_o, res_state_o, lr_we_o, res_pc_o, lr_val_o};
        total++;
        if (o !== '0) begin
            bad++;
            $display("FAIL R1: actual %h expected 0", o);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();                       // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_reset();                       // R1 after release, no request yet
        issue("R3 wide fail",       1, 2'b00, 0, 32'h1000, 0, 32'h40, 32'h0);
        issue("R3 compact fail",    1, 2'b00, 0, 32'h2002, 1, 32'h40, 32'h0);
        issue("R4 wide jump",       1, 2'b00, 1, 32'h8054, 0, 32'h10, 32'h0);
        issue("R4 compact back",    1, 2'b00, 1, 32'h3000, 1, 32'hFFFF_FFFA, 32'h0);
        issue("R4 wide odd offset", 1, 2'b00, 1, 32'h0100, 0, 32'h3, 32'h0);
        issue("R2 idle",            0, 2'b01, 1, 32'h5555, 0, 32'h8, 32'h9001);
        issue("R5 wide call",       1, 2'b01, 1, 32'h8054, 0, 32'h20, 32'h0);
        issue("R5 compact call",    1, 2'b01, 1, 32'h4000, 1, 32'h100, 32'h0);
        issue("R3 call fails",      1, 2'b01, 0, 32'h4100, 0, 32'h100, 32'h0);
        issue("R6 to compact",      1, 2'b10, 1, 32'h8054, 0, 32'h0, 32'h805D);
        issue("R6 to wide",         1, 2'b10, 1, 32'h9100, 1, 32'h0, 32'h9000);
        issue("R7 misalign wide",   1, 2'b10, 1, 32'h0500, 0, 32'h0, 32'h9002);
        issue("R7 misalign compact",1, 2'b10, 1, 32'h0600, 1, 32'h0, 32'hA002);
        issue("R8 call to compact", 1, 2'b11, 1, 32'h0700, 0, 32'h0, 32'hB001);
        issue("R8 call to wide",    1, 2'b11, 1, 32'h0710, 1, 32'h0, 32'hC000);
        issue("R7 R9 call misalign",1, 2'b11, 1, 32'h0800, 0, 32'h0, 32'hD002);
        issue("R9 swap fails",      1, 2'b11, 0, 32'h0900, 1, 32'h0, 32'hE001);
        issue("R2 idle tail",       0, 2'b00, 0, 32'h0, 0, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule